// File: doc/BRIEF.md
# One-Hot Return-to-Null Link Codec

This block holds both ends of a delay-insensitive parallel link. Each two-bit symbol travels on a group of four wires, and exactly one wire of the group goes high to carry it. A word is made of several such groups. Between words every wire drops back to all-low, the NULL spacer, so the link follows a four-phase return-to-zero handshake. Each rail that carries a symbol rises once and falls once, which is two wire transitions per group for each symbol.

The transmit side takes a parallel word with a valid/ready handshake. It drives the one-hot code for each group and holds it until the far end acknowledges. It then drives NULL and waits for the acknowledge to drop before it accepts the next word. The receive side watches the incoming rails. When every group holds exactly one high wire, it decodes the word, raises its acknowledge and pulses a data-valid strobe. It lowers the acknowledge only after every group has returned to NULL. Any group with more than one high wire is reported as illegal and is never decoded. The number of groups is a parameter, and the default of four gives an eight-bit word.

Top module: `onehot_rtz_codec`

## Requirements
- R1: Group g drives rails [4g+3:4g] from data bits [2g+1:2g]: symbol 00 gives 0001, 01 gives 0010, 10 gives 0100 and 11 gives 1000. No transmit group ever has more than one rail high.
- R2: While the transmitter is idle, `tx_ready` is high and the rails are all low. A cycle with `tx_valid` and `tx_ready` both high puts the code on `tx_rails` at the next edge and drops `tx_ready`.
- R3: The transmitter holds its code stable while `tx_ack` is low, whatever `tx_data` and `tx_valid` do. The first edge that sees `tx_ack` high drives all-low rails.
- R4: After driving NULL, the transmitter keeps the rails low and `tx_ready` low until it sees `tx_ack` low. `tx_ready` returns high on that edge.
- R5: `rx_ack` rises on the edge after every group of `rx_rails` holds exactly one high wire. While any group is still NULL, it stays low.
- R6: Once high, `rx_ack` stays high until every group of `rx_rails` is all-low. It falls on the edge that sees this.
- R7: `rx_valid` pulses for one cycle together with the rise of `rx_ack`, and `rx_data` then shows the decoded word using the R1 mapping. `rx_data` holds its value at all other times.
- R8: A group with two or more high wires sets `rx_illegal` on the next edge. It blocks the acknowledge and leaves `rx_data` unchanged.
- R9: Under reset, `tx_rails` is all-low, `tx_ready` is high, and `rx_ack`, `rx_valid` and `rx_illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 2*GROUPS | Word to send |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Transmitter idle, word will be taken |
| tx_rails | output | 4*GROUPS | Outgoing one-hot rails |
| tx_ack | input | 1 | Acknowledge from the far receiver |
| rx_rails | input | 4*GROUPS | Incoming one-hot rails |
| rx_ack | output | 1 | Acknowledge to the far transmitter |
| rx_data | output | 2*GROUPS | Last decoded word |
| rx_valid | output | 1 | One-cycle strobe on a new word |
| rx_illegal | output | 1 | A group showed more than one high wire |

## Verification
A wrong transmit state shows at the ports within one edge. Either a code reappears on `tx_rails` after the acknowledge, or `tx_ready` rises while the rails are non-NULL, or a second symbol appears before the acknowledge has fallen. A receive state that is out of step shows as an acknowledge that rises on a partial word or on an illegal group, or that drops before all rails are low. Each of these is visible on the edge after the rail pattern that should have prevented it. The bench therefore probes each rail pattern one cycle at a time, both in loopback and with injected patterns.

// File: rtl/onehot_pkg.sv
package onehot_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_CODE = 2'd1,
        TX_NULL = 2'd2
    } tx_state_e;

    function automatic logic [3:0] sym_to_code(input logic [1:0] sym);
        return 4'b0001 << sym;
    endfunction

    function automatic logic [1:0] code_to_sym(input logic [3:0] code);
        logic [1:0] s;
        unique case (code)
            4'b0010: s = 2'd1;
            4'b0100: s = 2'd2;
            4'b1000: s = 2'd3;
            default: s = 2'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/onehot_grp_enc.sv
module onehot_grp_enc
    import onehot_pkg::*;
(
    input  logic [1:0] sym,
    output logic [3:0] code
);
    always_comb begin
        code = sym_to_code(sym);
    end
endmodule

// File: rtl/onehot_grp_chk.sv
module onehot_grp_chk
    import onehot_pkg::*;
(
    input  logic [3:0] code,
    output logic       is_null,
    output logic       is_code,
    output logic       is_bad,
    output logic [1:0] sym
);
    logic [2:0] ones;

    always_comb begin
        ones = 3'(code[0]) + 3'(code[1]) + 3'(code[2]) + 3'(code[3]);
        is_null = (ones == 3'd0);
        is_code = (ones == 3'd1);
        is_bad  = (ones > 3'd1);
        sym     = code_to_sym(code);
    end
endmodule

// File: rtl/onehot_tx.sv
module onehot_tx
    import onehot_pkg::*;
#(
    parameter int GROUPS = 4,
    localparam int DW = 2 * GROUPS,
    localparam int RW = 4 * GROUPS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] data,
    input  logic          valid,
    output logic          ready,
    output logic [RW-1:0] rails,
    input  logic          ack
);
    typedef struct packed {
        tx_state_e     state;
        logic [RW-1:0] rails;
    } tx_regs_t;

    tx_regs_t      r_d, r_q;
    logic [RW-1:0] enc_w;

    for (genvar g = 0; g < GROUPS; g++) begin : g_enc
        onehot_grp_enc u_enc (
            .sym  (data[2*g +: 2]),
            .code (enc_w[4*g +: 4])
        );
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            TX_IDLE: begin
                if (valid) begin
                    r_d.state = TX_CODE;
                    r_d.rails = enc_w;
                end
            end
            TX_CODE: begin
                if (ack) begin
                    r_d.state = TX_NULL;
                    r_d.rails = '0;
                end
            end
            TX_NULL: begin
                if (!ack) begin
                    r_d.state = TX_IDLE;
                end
            end
            default: begin
                r_d.state = TX_IDLE;
                r_d.rails = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: TX_IDLE, rails: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ready = (r_q.state == TX_IDLE);
    assign rails = r_q.rails;
endmodule

// File: rtl/onehot_rx.sv
module onehot_rx
    import onehot_pkg::*;
#(
    parameter int GROUPS = 4,
    localparam int DW = 2 * GROUPS,
    localparam int RW = 4 * GROUPS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] rails,
    output logic          ack,
    output logic [DW-1:0] data,
    output logic          valid,
    output logic          illegal
);
    typedef struct packed {
        logic          ack;
        logic [DW-1:0] data;
        logic          valid;
        logic          illegal;
    } rx_regs_t;

    rx_regs_t            r_d, r_q;
    logic [GROUPS-1:0]   null_w, code_w, bad_w;
    logic [DW-1:0]       sym_w;

    for (genvar g = 0; g < GROUPS; g++) begin : g_chk
        onehot_grp_chk u_chk (
            .code    (rails[4*g +: 4]),
            .is_null (null_w[g]),
            .is_code (code_w[g]),
            .is_bad  (bad_w[g]),
            .sym     (sym_w[2*g +: 2])
        );
    end

    always_comb begin
        r_d         = r_q;
        r_d.valid   = 1'b0;
        r_d.illegal = |bad_w;
        if (!r_q.ack) begin
            if (&code_w) begin
                r_d.ack   = 1'b1;
                r_d.data  = sym_w;
                r_d.valid = 1'b1;
            end
        end else if (&null_w) begin
            r_d.ack = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack     = r_q.ack;
    assign data    = r_q.data;
    assign valid   = r_q.valid;
    assign illegal = r_q.illegal;
endmodule

// File: rtl/onehot_rtz_codec.sv
module onehot_rtz_codec #(
    parameter int GROUPS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*GROUPS-1:0]   tx_data,
    input  logic                  tx_valid,
    output logic                  tx_ready,
    output logic [4*GROUPS-1:0]   tx_rails,
    input  logic                  tx_ack,
    input  logic [4*GROUPS-1:0]   rx_rails,
    output logic                  rx_ack,
    output logic [2*GROUPS-1:0]   rx_data,
    output logic                  rx_valid,
    output logic                  rx_illegal
);
    onehot_tx #(.GROUPS(GROUPS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .data  (tx_data),
        .valid (tx_valid),
        .ready (tx_ready),
        .rails (tx_rails),
        .ack   (tx_ack)
    );

    onehot_rx #(.GROUPS(GROUPS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rails   (rx_rails),
        .ack     (rx_ack),
        .data    (rx_data),
        .valid   (rx_valid),
        .illegal (rx_illegal)
    );
endmodule

// File: rtl/onehot_rtz_codec_chk.sv
module onehot_rtz_codec_chk #(
    parameter int GROUPS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tx_ready,
    input logic [4*GROUPS-1:0] tx_rails,
    input logic                tx_ack,
    input logic [4*GROUPS-1:0] rx_rails,
    input logic                rx_ack,
    input logic                rx_valid,
    input logic                rx_illegal
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        p_tx_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(tx_rails[4*g +: 4]) <= 1);
    end

    p_idle_null_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (tx_rails == '0));

    p_null_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_rails != '0) && tx_ack) |=> (tx_rails == '0));

    p_hold_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_rails != '0) && !tx_ack) |=> $stable(tx_rails));

    p_wait_ack_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_rails == '0) && !tx_ready) |=> (tx_rails == '0));

    p_ack_fall_null_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_ack) |-> ($past(rx_rails) == '0));

    p_valid_with_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $rose(rx_ack));

    p_no_ack_on_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ack) |-> !rx_illegal);
endmodule

bind onehot_rtz_codec onehot_rtz_codec_chk #(.GROUPS(GROUPS)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_ready   (tx_ready),
    .tx_rails   (tx_rails),
    .tx_ack     (tx_ack),
    .rx_rails   (rx_rails),
    .rx_ack     (rx_ack),
    .rx_valid   (rx_valid),
    .rx_illegal (rx_illegal)
);

// File: tb/test_onehot_rtz_codec.sv
module test_onehot_rtz_codec;
    localparam int G  = 4;
    localparam int DW = 2 * G;
    localparam int RW = 4 * G;
    localparam int NV = 6;

    // stimulus word and the expected rail image (R1 mapping)
    localparam logic [DW+RW-1:0] VECS [NV] = '{
        {8'h00, 16'h1111},
        {8'hFF, 16'h8888},
        {8'h1B, 16'h1248},
        {8'hE4, 16'h8421},
        {8'h55, 16'h2222},
        {8'hAA, 16'h4444}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic          tx_valid = 1'b0;
    logic          tx_ready;
    logic [RW-1:0] tx_rails;
    logic          tx_ack;
    logic [RW-1:0] rx_rails;
    logic          rx_ack;
    logic [DW-1:0] rx_data;
    logic          rx_valid;
    logic          rx_illegal;

    logic          loop = 1'b1;
    logic [RW-1:0] inj_rails = '0;
    logic          inj_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    assign rx_rails = loop ? tx_rails : inj_rails;
    assign tx_ack   = loop ? rx_ack : inj_ack;

    always #10 clk = ~clk;

    onehot_rtz_codec #(.GROUPS(G)) i_onehot_rtz_codec (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_rails   (tx_rails),
        .tx_ack     (tx_ack),
        .rx_rails   (rx_rails),
        .rx_ack     (rx_ack),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_illegal (rx_illegal)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step();
        step();
        // R9 reset state
        check(tx_rails == '0, "R9 rails", 32'(tx_rails), 0);
        check(tx_ready == 1'b1, "R9 ready", 32'(tx_ready), 1);
        check({rx_ack, rx_valid, rx_illegal} == 3'b000, "R9 rx outs",
              32'({rx_ack, rx_valid, rx_illegal}), 0);
        rst_n = 1'b1;
        step();

        // loopback vector walk
        for (int i = 0; i < NV; i++) begin
            logic [DW-1:0] d;
            logic [RW-1:0] e;
            d = VECS[i][DW+RW-1:RW];
            e = VECS[i][RW-1:0];
            check(tx_ready == 1'b1, "R2 ready idle", 32'(tx_ready), 1);
            tx_data  = d;
            tx_valid = 1'b1;
            step();
            tx_valid = 1'b0;
            check(tx_rails == e, "R1 code", 32'(tx_rails), 32'(e));
            check(tx_ready == 1'b0, "R2 ready drop", 32'(tx_ready), 0);
            step();
            check(rx_ack && rx_valid, "R5 ack rise", 32'({rx_ack, rx_valid}), 3);
            check(rx_data == d, "R7 decoded", 32'(rx_data), 32'(d));
            step();
            check(tx_rails == '0, "R3 null", 32'(tx_rails), 0);
            check(rx_valid == 1'b0, "R7 pulse", 32'(rx_valid), 0);
            step();
            check(rx_ack == 1'b0, "R6 ack fall", 32'(rx_ack), 0);
            check(tx_ready == 1'b0, "R4 still waiting", 32'(tx_ready), 0);
            step();
            check(tx_ready == 1'b1, "R4 ready back", 32'(tx_ready), 1);
        end

        // injected receive patterns
        loop = 1'b0;
        inj_rails = 16'h1113;
        step();
        check(rx_illegal == 1'b1, "R8 illegal", 32'(rx_illegal), 1);
        check(rx_ack == 1'b0, "R8 no ack", 32'(rx_ack), 0);
        check(rx_data == 8'hAA, "R8 data held", 32'(rx_data), 32'hAA);
        inj_rails = '0;
        step();
        check(rx_illegal == 1'b0, "R8 illegal clear", 32'(rx_illegal), 0);

        inj_rails = 16'h0111;
        step();
        check(rx_ack == 1'b0, "R5 partial", 32'(rx_ack), 0);
        inj_rails = 16'h4111;
        step();
        check(rx_ack && rx_valid, "R5 complete", 32'({rx_ack, rx_valid}), 3);
        check(rx_data == 8'h80, "R7 injected decode", 32'(rx_data), 32'h80);
        inj_rails = 16'h0111;
        step();
        check(rx_ack == 1'b1, "R6 partial null holds", 32'(rx_ack), 1);
        check(rx_valid == 1'b0, "R7 no repeat", 32'(rx_valid), 0);
        inj_rails = '0;
        step();
        check(rx_ack == 1'b0, "R6 full null", 32'(rx_ack), 0);

        // transmitter hold behaviour with manual acknowledge
        inj_ack  = 1'b0;
        tx_data  = 8'h1B;
        tx_valid = 1'b1;
        step();
        check(tx_rails == 16'h1248, "R1 manual code", 32'(tx_rails), 32'h1248);
        tx_data = 8'hFF;
        for (int k = 0; k < 3; k++) begin
            step();
            check(tx_rails == 16'h1248, "R3 hold code", 32'(tx_rails), 32'h1248);
            check(tx_ready == 1'b0, "R3 not ready", 32'(tx_ready), 0);
        end
        inj_ack = 1'b1;
        step();
        check(tx_rails == '0, "R3 null on ack", 32'(tx_rails), 0);
        for (int k = 0; k < 3; k++) begin
            step();
            check(tx_rails == '0, "R4 no new code", 32'(tx_rails), 0);
            check(tx_ready == 1'b0, "R4 blocked", 32'(tx_ready), 0);
        end
        inj_ack = 1'b0;
        step();
        check(tx_ready == 1'b1, "R4 released", 32'(tx_ready), 1);
        step();
        check(tx_rails == 16'h8888, "R2 next word taken", 32'(tx_rails), 32'h8888);
        tx_valid = 1'b0;
        inj_ack = 1'b1;
        step();
        inj_ack = 1'b0;
        step();
        step();

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule